// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target device still holds low on SDA after a transfer was cut short. A one-cycle request starts a recovery. The block holds SCL low and releases SDA, then checks whether SDA has come back high. While SDA stays low it issues slow clock pulses on SCL, up to a fixed limit. A target that is shifting out zero bytes lets go of SDA only in the acknowledge slot or on a 1 bit, so the pulses are meant to walk it to such a slot. After the pulses the block always creates a STOP condition by hand. It then gives a one-cycle done pulse and a flag that says whether SDA was seen released.

Both lines are open-drain. Each is controlled by an enable output, where 1 pulls the wire low and 0 lets it float high on the pull-up. The SDA wire is read back through a two-flop synchronizer. Every phase lasts one half period, and the number of system clocks in a half period is derived at elaboration from the clock frequency and a time in microseconds.

Top module: `i2c_bus_unjam`

## Requirements
- R1: After reset and while idle, `scl_pull_o`, `sda_pull_o`, `busy_o` and `done_o` are all 0 (0 means the line is released), and `sda_free_o` is 0 after reset.
- R2: A `kick_i` pulse sampled while idle makes `busy_o` 1 from the next cycle. For one half period SCL is then pulled low (`scl_pull_o`=1) and SDA is released (`sda_pull_o`=0), and SDA is sampled in the last cycle of that phase.
- R3: A half period lasts HALF = (CLK_HZ / 1000000) * HALF_US system clocks, and never fewer than 4. A recovery that issues p pulses keeps `busy_o` high for HALF*(4+2p)+1 cycles.
- R4: When the synchronized SDA sample is 0 and fewer than MAX_PULSES pulses have been issued (default 9), one pulse is issued: SCL is released for a half period, then pulled low for a half period, with SDA released throughout. SDA is sampled again in the last cycle of the low half.
- R5: A recovery issues exactly min(k, MAX_PULSES) pulses when the target releases SDA on the k-th rising edge of SCL, and never more than MAX_PULSES.
- R6: When the pulses end, the STOP sequence runs. First SDA and SCL are both pulled low for a half period. Then SCL is released with SDA still low for a half period. Then both are released for a half period, so SDA rises while SCL is high.
- R7: `done_o` is 1 for exactly one cycle, right after the last STOP phase, with both lines released. `busy_o` falls in the cycle after.
- R8: `sda_free_o` takes the value of the SDA sample that ended the pulse loop. It changes in the first cycle of the STOP sequence and holds until the next recovery reaches that point: 1 if SDA was high, 0 if the limit was hit with SDA still low.
- R9: A `kick_i` pulse that arrives while `busy_o` is 1, including the done cycle, has no effect on the line enables, the timing or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick_i | input | 1 | One-cycle request to start a recovery |
| sda_in_i | input | 1 | Level read back from the SDA wire |
| scl_pull_o | output | 1 | Open-drain enable for SCL, 1 pulls low |
| sda_pull_o | output | 1 | Open-drain enable for SDA, 1 pulls low |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle pulse at the end of a recovery |
| sda_free_o | output | 1 | SDA was seen high when the pulse loop ended |

## Verification
The bench builds the block with CLK_HZ = 10000000 and HALF_US = 1, which gives a 10-cycle half period, and keeps the default limit of 9 pulses. With these values a full recovery takes at most a couple of hundred cycles. That makes room for runs where the target lets go at once, after a few pulses, exactly on the ninth pulse, one pulse too late, and never. It also allows runs where requests arrive mid-recovery and in the done cycle, and recoveries started back to back. A behavioural target model releases SDA after a set number of SCL rising edges, and a queue of expected line states is compared with the outputs on every clock.

// File: rtl/i2crec_pkg.sv
package i2crec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_CLKHI  = 3'd2,
    ST_CLKLO  = 3'd3,
    ST_SDALO  = 3'd4,
    ST_SCLHI  = 3'd5,
    ST_FREE   = 3'd6,
    ST_DONE   = 3'd7
  } rec_state_e;

  // System clocks in one half period, floored at four.
  function automatic int half_cycles(int clk_hz, int half_us);
    int c;
    c = (clk_hz / 1000000) * half_us;
    return (c < 4) ? 4 : c;
  endfunction

  // Bits needed to count pulses up to the limit.
  function automatic int count_bits(int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

  // Phases in which the sequencer pulls SCL low.
  function automatic logic scl_pulled(rec_state_e s);
    return (s == ST_SETTLE) || (s == ST_CLKLO) || (s == ST_SDALO);
  endfunction

  // Phases in which the sequencer pulls SDA low.
  function automatic logic sda_pulled(rec_state_e s);
    return (s == ST_SDALO) || (s == ST_SCLHI);
  endfunction

  // Phases that last one half period.
  function automatic logic timed_phase(rec_state_e s);
    return (s != ST_IDLE) && (s != ST_DONE);
  endfunction

endpackage

// File: rtl/i2crec_sync.sv
module i2crec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b1;
        else if (g == 0) chain_q[g] <= d_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2crec_timer.sv
module i2crec_timer #(
  parameter int HALF = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  // Ticks inside one running stretch are at least HALF cycles apart.
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && run_i) |=> !tick_o);
endmodule

// File: rtl/i2crec_fsm.sv
module i2crec_fsm
  import i2crec_pkg::*;
#(
  parameter int MAX_PULSES = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kick_i,
  input  logic       tick_i,
  input  logic       sda_s_i,
  output rec_state_e state_o,
  output logic       run_o,
  output logic       decide_o,
  output logic       free_o
);
  localparam int PW = count_bits(MAX_PULSES);
  localparam logic [PW-1:0] LIMIT = PW'(MAX_PULSES);

  rec_state_e state_q, state_n;
  logic [PW-1:0] pulses_q, pulses_n, cand_w;
  logic free_q, free_n;
  logic decide_w;

  assign decide_w = tick_i && (state_q == ST_SETTLE || state_q == ST_CLKLO);
  assign cand_w   = (state_q == ST_CLKLO) ? pulses_q + 1'b1 : '0;

  always_comb begin
    state_n  = state_q;
    pulses_n = pulses_q;
    free_n   = free_q;
    unique case (state_q)
      ST_IDLE: if (kick_i) begin
        state_n  = ST_SETTLE;
        pulses_n = '0;
      end
      ST_SETTLE, ST_CLKLO: if (decide_w) begin
        pulses_n = cand_w;
        if (!sda_s_i && (cand_w < LIMIT)) state_n = ST_CLKHI;
        else begin
          state_n = ST_SDALO;
          free_n  = sda_s_i;
        end
      end
      ST_CLKHI: if (tick_i) state_n = ST_CLKLO;
      ST_SDALO: if (tick_i) state_n = ST_SCLHI;
      ST_SCLHI: if (tick_i) state_n = ST_FREE;
      ST_FREE:  if (tick_i) state_n = ST_DONE;
      ST_DONE:  state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pulses_q <= '0;
      free_q   <= 1'b0;
    end else begin
      state_q  <= state_n;
      pulses_q <= pulses_n;
      free_q   <= free_n;
    end
  end

  assign state_o  = state_q;
  assign run_o    = timed_phase(state_q);
  assign decide_o = decide_w;
  assign free_o   = free_q;

  // The pulse count never passes the limit.
  assert_pulse_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulses_q <= LIMIT);

  // Once past the settle phase, no request restarts the sequence.
  assert_kick_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_SETTLE) |=> state_q != ST_SETTLE);

  // A high SDA sample always ends the pulse loop.
  assert_high_ends_loop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_w && sda_s_i) |=> state_q == ST_SDALO);

  // The result flag moves only at a loop decision.
  assert_flag_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !decide_w |=> $stable(free_q));
endmodule

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam
  import i2crec_pkg::*;
#(
  parameter int CLK_HZ     = 100000000,
  parameter int HALF_US    = 5,
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic sda_in_i,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic busy_o,
  output logic done_o,
  output logic sda_free_o
);
  localparam int HALF = half_cycles(CLK_HZ, HALF_US);

  rec_state_e state_w;
  logic sda_s_w, tick_w, run_w, decide_w, free_w;

  i2crec_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sda_in_i), .q_o(sda_s_w)
  );

  i2crec_timer #(.HALF(HALF)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(run_w), .tick_o(tick_w)
  );

  i2crec_fsm #(.MAX_PULSES(MAX_PULSES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .kick_i(kick_i), .tick_i(tick_w),
    .sda_s_i(sda_s_w), .state_o(state_w), .run_o(run_w),
    .decide_o(decide_w), .free_o(free_w)
  );

  assign scl_pull_o = scl_pulled(state_w);
  assign sda_pull_o = sda_pulled(state_w);
  assign busy_o     = (state_w != ST_IDLE);
  assign done_o     = (state_w == ST_DONE);
  assign sda_free_o = free_w;

  // A recovery opens with SCL held low and SDA let go.
  assert_open_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (scl_pull_o && !sda_pull_o));

  // SDA is let go only while SCL is released: the STOP edge.
  assert_stop_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_o) |-> !scl_pull_o);

  // Done lasts one cycle and ends the busy window.
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
endmodule

// File: tb/i2c_bus_unjam_test.sv
module i2c_bus_unjam_test;
  localparam int H    = 10;
  localparam int MAXP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kick = 1'b0;
  int   edges_left = 0;
  always #5 clk = ~clk;

  logic scl_pull, sda_pull, busy, done, sda_free;
  wire  sda_line = !sda_pull && (edges_left == 0);
  wire  scl_line = !scl_pull;

  // Stuck target: lets go of SDA after a set number of SCL rising edges.
  always @(posedge scl_line) if (edges_left > 0) edges_left <= edges_left - 1;

  i2c_bus_unjam #(.CLK_HZ(10000000), .HALF_US(1), .MAX_PULSES(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .kick_i(kick), .sda_in_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .busy_o(busy),
    .done_o(done), .sda_free_o(sda_free)
  );

  int checks = 0, fails = 0;
  logic [4:0] q_exp[$];
  string      q_tag[$];
  bit model_free = 1'b0;
  bit comparing = 1'b0;
  int busy_cnt = 0, rise_cnt = 0;
  bit prev_scl = 1'b0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(logic [4:0] v, string t, int n);
    for (int i = 0; i < n; i++) begin q_exp.push_back(v); q_tag.push_back(t); end
  endtask

  // Expected {busy, scl_pull, sda_pull, done, sda_free} per cycle.
  task automatic model_run(int k);
    int p; bit nf;
    p  = (k < MAXP) ? k : MAXP;
    nf = (k <= MAXP);
    push({4'b0000, model_free}, "R1", 1);
    push({4'b1100, model_free}, "R2", H);
    for (int i = 0; i < p; i++) begin
      push({4'b1000, model_free}, "R4", H);
      push({4'b1100, model_free}, "R4", H);
    end
    push({4'b1110, nf}, "R6", H);
    push({4'b1010, nf}, "R6", H);
    push({4'b1000, nf}, "R6", H);
    push({4'b1001, nf}, "R7", 1);
    model_free = nf;
  endtask

  // Per-clock comparison, sampled away from the edge.
  initial begin
    forever begin
      @(posedge clk); #4;
      if (comparing) begin
        logic [4:0] e; string t;
        if (q_exp.size() > 0) begin e = q_exp.pop_front(); t = q_tag.pop_front(); end
        else begin e = {4'b0000, model_free}; t = "R9"; end
        check(t, {busy, scl_pull, sda_pull, done, sda_free}, e);
        if (busy) busy_cnt++;
        if (busy && prev_scl && !scl_pull && !sda_pull) rise_cnt++;
        prev_scl = scl_pull;
      end
    end
  end

  task automatic recover(int k, bit poke);
    int p;
    p = (k < MAXP) ? k : MAXP;
    @(posedge clk); #1;
    edges_left = k; busy_cnt = 0; rise_cnt = 0;
    kick = 1'b1;
    if (q_exp.size() == 0) model_run(k);
    @(posedge clk); #1; kick = 1'b0;
    if (poke) begin
      repeat (H + 3) @(posedge clk);
      #1 kick = 1'b1; @(posedge clk); #1 kick = 1'b0;
      repeat (2 * H) @(posedge clk);
      #1 kick = 1'b1; @(posedge clk); #1 kick = 1'b0;
      while (q_exp.size() > 1) begin @(posedge clk); #1; end
      kick = 1'b1; @(posedge clk); #1 kick = 1'b0;
    end
    while (q_exp.size() > 0) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    check("R5", rise_cnt, p);
    check("R3", busy_cnt, H * (4 + 2 * p) + 1);
    check("R8", sda_free, (k <= MAXP) ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #4;
    check("R1", {scl_pull, sda_pull, busy, done, sda_free}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", {scl_pull, sda_pull, busy, done}, 0);
    comparing = 1'b1;
    recover(0, 1'b0);
    recover(3, 1'b0);
    recover(MAXP, 1'b0);
    recover(MAXP + 1, 1'b0);
    recover(1, 1'b1);
    recover(40, 1'b1);
    recover(2, 1'b0);
    repeat (5) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule